// File: doc/BRIEF.md
# Serial Flash Chip-Erase Controller

This block is the instruction front end and erase sequencer of a serial NOR flash slave. A host frames each instruction with an active-low chip select and a serial clock. In single-line mode the opcode arrives one bit per clock on io[0]. In four-line mode it arrives one nibble per clock on io[3:0]. The host clock may idle low or idle high, and data is always taken on its rising edge. The chip select, clock and data lines are oversampled in the system clock domain.

Two opcodes start an erase of the whole array. The erase is committed only when all of these hold: chip select returns high exactly on the byte boundary, the write-enable latch is set, and the protection setting leaves the whole array open. The erase is self-timed. It fills the internal array with all-ones and then clears the write-enable latch. During that time the status instruction keeps answering, so the host can poll the busy flag. The array also has a plain write port and a plain read port, which a neighbouring program path and read path use.

Top module: `flash_erase_ctrl`

## Requirements
- R1: An erase opcode (C7h or 60h) starts an erase, and the status busy bit reads 1 afterwards. This needs three conditions: the opcode is framed in exactly 8 bits, the write-enable latch is 1, and the array is unprotected. Any other opcode (for example 20h) starts nothing.
- R2: When the write-enable latch is 0, an erase opcode is ignored: busy stays 0 and the array keeps its contents.
- R3: When chip select rises after any bit count other than exactly 8, the instruction is discarded, whether it is erase or write enable. Examples are 7 or 9 clocks in single-line mode, and 1 or 3 clocks in four-line mode.
- R4: prot_cfg is encoded as [5]=complement, [4]=sector, [3]=top/bottom, [2:0]=level. The erase is refused unless one of two settings holds: complement=0 with level=000, or complement=1 with level=111. The sector and top/bottom bits never change this decision.
- R5: Once started, busy stays 1 for max(ERASE_CYCLES, DEPTH) system clocks and then returns to 0. After that, every array location reads FFh.
- R6: Status opcode 05h returns the byte {6'b0, WEL, BUSY}: BUSY in bit 0 and WEL in bit 1. The byte is sent MSB first, starting at the clock fall after the last opcode bit, and is refreshed for each further byte clocked. It is served during an erase.
- R7: Write-enable opcode 06h, framed in exactly 8 bits, sets the write-enable latch. The latch is cleared to 0 when an erase finishes.
- R8: While busy, every instruction except a status read is ignored: write enable does nothing and a second erase does not restart the timer. Writes on the array write port are also ignored.
- R9: In single-line mode the block drives only io[1] (io_oe=0010b), and only while it returns status. During an instruction io_oe is 0. In four-line mode status comes back as two nibbles, high nibble first, with io_oe=1111b.
- R10: Both clock idle levels (low and high) are accepted, with data sampled on the rising clock edge.
- R11: After reset, busy=0, WEL=0 and io_oe=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Host chip select, active low |
| sck | input | 1 | Host serial clock |
| io_in | input | 4 | Host data lines (io_in[0] only in single-line mode) |
| qpi_mode | input | 1 | 1 selects four-line instruction mode |
| prot_cfg | input | 6 | Protection setting {complement, sector, top/bottom, level[2:0]} |
| io_out | output | 4 | Data driven back to the host |
| io_oe | output | 4 | Output enable per data line |
| arr_wr_en | input | 1 | Array write strobe from the program path |
| arr_wr_addr | input | ADDR_W | Array write address |
| arr_wr_data | input | DATA_W | Array write data |
| arr_rd_addr | input | ADDR_W | Array read address |
| arr_rd_data | output | DATA_W | Array read data, one cycle after the address |

## Verification
A wrong write-enable latch or wrong commit decision shows up in the very next status read. It appears either as a busy bit set where none was expected, or as a WEL bit that survived an erase or a refused frame. A miscounted bit counter or a wrong protection decode shows the same symptom, and it is also visible as unchanged array bytes after the erase window. A timer that restarts while busy keeps the busy bit set tens of cycles past the nominal end. A status read placed just after that end tells the two apart. A drive-enable fault shows at io_oe during the instruction phase itself.

// File: rtl/fe_pkg.sv
package fe_pkg;
  localparam logic [7:0] OP_ERASE_A = 8'hC7;
  localparam logic [7:0] OP_ERASE_B = 8'h60;
  localparam logic [7:0] OP_WREN    = 8'h06;
  localparam logic [7:0] OP_STATUS  = 8'h05;

  typedef struct packed {
    logic       cmp;
    logic       sec;
    logic       tb;
    logic [2:0] lvl;
  } prot_t;

  // Whole-array erase is allowed only if no part of the array is guarded.
  function automatic logic array_open(input prot_t p);
    return (!p.cmp && p.lvl == 3'b000) || (p.cmp && p.lvl == 3'b111);
  endfunction

  function automatic logic is_erase(input logic [7:0] op);
    return (op == OP_ERASE_A) || (op == OP_ERASE_B);
  endfunction
endpackage

// File: rtl/fe_front.sv
module fe_front #(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       cs_n,
  input  logic       sck,
  input  logic [3:0] io_in,
  input  logic       qpi,
  output logic       cs_hi,
  output logic       sck_fall,
  output logic       byte_done,
  output logic       frame_end,
  output logic       exact8,
  output logic [7:0] opcode
);
  localparam int          LAST = SYNC_STAGES - 1;
  localparam logic [3:0]  FULL = 4'd8;
  localparam logic [3:0]  OVER = 4'd9;

  logic [SYNC_STAGES-1:0] cs_sync, sck_sync;
  logic [3:0]             io_sync [SYNC_STAGES];
  logic                   cs_q, sck_q;
  logic [3:0]             bitcnt;
  logic [3:0]             step;
  logic                   sck_rise;

  always_ff @(posedge clk) begin
    if (rst) begin
      cs_sync  <= '1;
      sck_sync <= '0;
    end else begin
      cs_sync  <= {cs_sync[SYNC_STAGES-2:0], cs_n};
      sck_sync <= {sck_sync[SYNC_STAGES-2:0], sck};
    end
  end

  generate
    for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_io_sync
      always_ff @(posedge clk) begin
        if (rst) io_sync[s] <= '0;
        else if (s == 0) io_sync[s] <= io_in;
        else io_sync[s] <= io_sync[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign cs_hi    = cs_sync[LAST];
  assign step     = qpi ? 4'd4 : 4'd1;
  assign sck_rise = sck_sync[LAST] && !sck_q && !cs_hi;
  assign sck_fall = !sck_sync[LAST] && sck_q && !cs_hi;

  always_ff @(posedge clk) begin
    if (rst) begin
      cs_q      <= 1'b1;
      sck_q     <= 1'b0;
      bitcnt    <= '0;
      opcode    <= '0;
      byte_done <= 1'b0;
      frame_end <= 1'b0;
      exact8    <= 1'b0;
    end else begin
      cs_q      <= cs_hi;
      sck_q     <= sck_sync[LAST];
      byte_done <= 1'b0;
      frame_end <= 1'b0;
      if (cs_hi && !cs_q) begin
        frame_end <= 1'b1;
        exact8    <= (bitcnt == FULL);
      end
      if (!cs_hi && cs_q) begin
        bitcnt <= '0;
      end else if (sck_rise) begin
        if (bitcnt < FULL) begin
          opcode <= qpi ? {opcode[3:0], io_sync[LAST]} : {opcode[6:0], io_sync[LAST][0]};
          bitcnt <= bitcnt + step;
          if (bitcnt + step == FULL) byte_done <= 1'b1;
        end else begin
          bitcnt <= OVER;
        end
      end
    end
  end

  AST_BITCNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    bitcnt <= OVER); // R3
  AST_BYTE_AT_EIGHT: assert property (@(posedge clk) disable iff (rst)
    byte_done |-> bitcnt == FULL); // R3
endmodule

// File: rtl/fe_status.sv
module fe_status
  import fe_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       cs_hi,
  input  logic       sck_fall,
  input  logic       byte_done,
  input  logic [7:0] opcode,
  input  logic       qpi,
  input  logic       busy,
  input  logic       wel,
  output logic [3:0] io_out,
  output logic [3:0] io_oe
);
  logic       armed, active;
  logic [7:0] sh;
  logic [3:0] left;
  logic [7:0] live;
  logic [3:0] per_byte;

  assign live     = {6'b0, wel, busy};
  assign per_byte = qpi ? 4'd2 : 4'd8;

  always_ff @(posedge clk) begin
    if (rst) begin
      armed  <= 1'b0;
      active <= 1'b0;
      sh     <= '0;
      left   <= '0;
    end else if (cs_hi) begin
      armed  <= 1'b0;
      active <= 1'b0;
    end else begin
      if (byte_done && opcode == OP_STATUS) armed <= 1'b1;
      if (sck_fall) begin
        if (armed) begin
          armed  <= 1'b0;
          active <= 1'b1;
          sh     <= live;
          left   <= per_byte;
        end else if (active) begin
          if (left == 4'd1) begin
            sh   <= live;
            left <= per_byte;
          end else begin
            sh   <= qpi ? {sh[3:0], 4'b0} : {sh[6:0], 1'b0};
            left <= left - 4'd1;
          end
        end
      end
    end
  end

  assign io_out = qpi ? sh[7:4] : {2'b00, sh[7], 1'b0};
  assign io_oe  = active ? (qpi ? 4'b1111 : 4'b0010) : 4'b0000;

  AST_OE_RELEASE: assert property (@(posedge clk) disable iff (rst)
    cs_hi |=> io_oe == 4'b0000); // R9
  AST_DRIVE_AFTER_OPCODE: assert property (@(posedge clk) disable iff (rst)
    $rose(active) |-> $past(armed)); // R6
endmodule

// File: rtl/fe_seq.sv
module fe_seq
  import fe_pkg::*;
#(
  parameter int DEPTH        = 256,
  parameter int ERASE_CYCLES = 1024,
  localparam int ADDR_W      = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              frame_end,
  input  logic              exact8,
  input  logic [7:0]        opcode,
  input  prot_t             prot,
  output logic              busy,
  output logic              wel,
  output logic              sweep_we,
  output logic [ADDR_W-1:0] sweep_addr
);
  localparam int RUN   = (ERASE_CYCLES > DEPTH) ? ERASE_CYCLES : DEPTH;
  localparam int CNT_W = $clog2(RUN + 1);
  localparam logic [CNT_W-1:0] RUN_LAST = CNT_W'(RUN - 1);
  localparam logic [CNT_W-1:0] SWEEP_N  = CNT_W'(DEPTH);

  logic [CNT_W-1:0] tmr;
  logic             framed, take_erase, take_wren;

  assign framed     = frame_end && exact8 && !busy;
  assign take_erase = framed && is_erase(opcode) && wel && array_open(prot);
  assign take_wren  = framed && opcode == OP_WREN;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      wel  <= 1'b0;
      tmr  <= '0;
    end else if (busy) begin
      if (tmr == RUN_LAST) begin
        busy <= 1'b0;
        wel  <= 1'b0;
      end else begin
        tmr <= tmr + 1'b1;
      end
    end else if (take_erase) begin
      busy <= 1'b1;
      tmr  <= '0;
    end else if (take_wren) begin
      wel <= 1'b1;
    end
  end

  assign sweep_we   = busy && (tmr < SWEEP_N);
  assign sweep_addr = tmr[ADDR_W-1:0];

  AST_ERASE_NEEDS_WEL: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(wel)); // R2
  AST_ERASE_ON_BOUNDARY: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(frame_end && exact8)); // R3
  AST_ERASE_UNGUARDED: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(array_open(prot))); // R4
  AST_WEL_CLEARED: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> !wel); // R7
  AST_NO_WEL_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
    $rose(wel) |-> !$past(busy)); // R8
endmodule

// File: rtl/fe_array.sv
module fe_array #(
  parameter int DEPTH  = 256,
  parameter int DATA_W = 8,
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/flash_erase_ctrl.sv
module flash_erase_ctrl
  import fe_pkg::*;
#(
  parameter int DEPTH        = 256,
  parameter int DATA_W       = 8,
  parameter int ERASE_CYCLES = 1024,
  parameter int SYNC_STAGES  = 2,
  localparam int ADDR_W      = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_n,
  input  logic              sck,
  input  logic [3:0]        io_in,
  input  logic              qpi_mode,
  input  logic [5:0]        prot_cfg,
  output logic [3:0]        io_out,
  output logic [3:0]        io_oe,
  input  logic              arr_wr_en,
  input  logic [ADDR_W-1:0] arr_wr_addr,
  input  logic [DATA_W-1:0] arr_wr_data,
  input  logic [ADDR_W-1:0] arr_rd_addr,
  output logic [DATA_W-1:0] arr_rd_data
);
  localparam logic [DATA_W-1:0] BLANK = {DATA_W{1'b1}};

  logic              cs_hi, sck_fall, byte_done, frame_end, exact8;
  logic [7:0]        opcode;
  logic              busy, wel, sweep_we;
  logic [ADDR_W-1:0] sweep_addr;
  logic              mem_we;
  logic [ADDR_W-1:0] mem_waddr;
  logic [DATA_W-1:0] mem_wdata;

  fe_front #(.SYNC_STAGES(SYNC_STAGES)) u_front (
    .clk(clk), .rst(rst), .cs_n(cs_n), .sck(sck), .io_in(io_in), .qpi(qpi_mode),
    .cs_hi(cs_hi), .sck_fall(sck_fall), .byte_done(byte_done),
    .frame_end(frame_end), .exact8(exact8), .opcode(opcode)
  );

  fe_seq #(.DEPTH(DEPTH), .ERASE_CYCLES(ERASE_CYCLES)) u_seq (
    .clk(clk), .rst(rst), .frame_end(frame_end), .exact8(exact8), .opcode(opcode),
    .prot(prot_t'(prot_cfg)), .busy(busy), .wel(wel),
    .sweep_we(sweep_we), .sweep_addr(sweep_addr)
  );

  fe_status u_status (
    .clk(clk), .rst(rst), .cs_hi(cs_hi), .sck_fall(sck_fall), .byte_done(byte_done),
    .opcode(opcode), .qpi(qpi_mode), .busy(busy), .wel(wel),
    .io_out(io_out), .io_oe(io_oe)
  );

  // The erase owns the write port while busy; program-path writes are dropped.
  assign mem_we    = busy ? sweep_we : arr_wr_en;
  assign mem_waddr = busy ? sweep_addr : arr_wr_addr;
  assign mem_wdata = busy ? BLANK : arr_wr_data;

  fe_array #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_array (
    .clk(clk), .we(mem_we), .waddr(mem_waddr), .wdata(mem_wdata),
    .raddr(arr_rd_addr), .rdata(arr_rd_data)
  );

  AST_HOST_WRITE_BLOCKED: assert property (@(posedge clk) disable iff (rst)
    busy && mem_we |-> mem_wdata == BLANK); // R8
endmodule

// File: tb/tb_flash_erase_ctrl.sv
module tb_flash_erase_ctrl;
  localparam int DEPTH  = 64;
  localparam int DATA_W = 8;
  localparam int ADDR_W = $clog2(DEPTH);
  localparam int ERASE  = 400;
  localparam int HALF   = 4;

  typedef struct packed {
    logic       qpi;
    logic       m3;
    logic       wren;
    logic [7:0] op;
    logic [3:0] nclk;
    logic [5:0] prot;
    logic       exp;
  } vec_t;

  localparam vec_t VEC [12] = '{
    '{1'b0, 1'b0, 1'b1, 8'hC7, 4'd8, 6'b000000, 1'b1},
    '{1'b0, 1'b1, 1'b1, 8'h60, 4'd8, 6'b000000, 1'b1},
    '{1'b1, 1'b0, 1'b1, 8'hC7, 4'd2, 6'b000000, 1'b1},
    '{1'b1, 1'b1, 1'b1, 8'h60, 4'd2, 6'b000000, 1'b1},
    '{1'b0, 1'b0, 1'b0, 8'hC7, 4'd8, 6'b000000, 1'b0},
    '{1'b0, 1'b0, 1'b1, 8'hC7, 4'd7, 6'b000000, 1'b0},
    '{1'b0, 1'b0, 1'b1, 8'hC7, 4'd9, 6'b000000, 1'b0},
    '{1'b1, 1'b0, 1'b1, 8'hC7, 4'd3, 6'b000000, 1'b0},
    '{1'b0, 1'b0, 1'b1, 8'hC7, 4'd8, 6'b000001, 1'b0},
    '{1'b0, 1'b0, 1'b1, 8'hC7, 4'd8, 6'b111111, 1'b1},
    '{1'b0, 1'b0, 1'b1, 8'h60, 4'd8, 6'b100000, 1'b0},
    '{1'b0, 1'b0, 1'b1, 8'h20, 4'd8, 6'b000000, 1'b0}
  };

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              cs_n = 1'b1;
  logic              sck = 1'b0;
  logic [3:0]        io_in = '0;
  logic              qpi_mode = 1'b0;
  logic [5:0]        prot_cfg = '0;
  logic [3:0]        io_out, io_oe;
  logic              arr_wr_en = 1'b0;
  logic [ADDR_W-1:0] arr_wr_addr = '0;
  logic [DATA_W-1:0] arr_wr_data = '0;
  logic [ADDR_W-1:0] arr_rd_addr = '0;
  logic [DATA_W-1:0] arr_rd_data;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  int t_cs = 0;
  logic oe_seen = 1'b0;

  flash_erase_ctrl #(.DEPTH(DEPTH), .DATA_W(DATA_W), .ERASE_CYCLES(ERASE)) dut (
    .clk(clk), .rst(rst), .cs_n(cs_n), .sck(sck), .io_in(io_in), .qpi_mode(qpi_mode),
    .prot_cfg(prot_cfg), .io_out(io_out), .io_oe(io_oe),
    .arr_wr_en(arr_wr_en), .arr_wr_addr(arr_wr_addr), .arr_wr_data(arr_wr_data),
    .arr_rd_addr(arr_rd_addr), .arr_rd_data(arr_rd_data)
  );

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_until(input int t);
    while (cyc < t) tick(1);
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1; cs_n = 1'b1; sck = 1'b0;
    tick(4);
    rst = 1'b0;
    tick(2);
  endtask

  function automatic logic [3:0] lane(input logic q, input logic [7:0] b, input int k);
    if (q) return (k == 0) ? b[7:4] : (k == 1) ? b[3:0] : 4'h0;
    return {3'b000, (k < 8) ? b[7-k] : 1'b0};
  endfunction

  task automatic shift_in(input logic q, input logic [7:0] b, input int nclk);
    for (int k = 0; k < nclk; k++) begin
      sck = 1'b0;
      io_in = lane(q, b, k);
      tick(HALF);
      if (!q && io_oe != 4'h0) oe_seen = 1'b1;
      sck = 1'b1;
      tick(HALF);
    end
  endtask

  task automatic end_frame(input logic m3);
    if (!m3) begin sck = 1'b0; tick(HALF); end
    cs_n = 1'b1;
    t_cs = cyc;
    tick(2 * HALF);
  endtask

  task automatic send_frame(input logic q, input logic m3, input logic [7:0] b, input int nclk);
    qpi_mode = q; sck = m3;
    tick(1);
    cs_n = 1'b0;
    tick(HALF);
    shift_in(q, b, nclk);
    end_frame(m3);
  endtask

  task automatic read_status(input logic q, input logic m3, output logic [7:0] st, output logic [3:0] oe);
    qpi_mode = q; sck = m3; st = '0; oe = '0;
    tick(1);
    cs_n = 1'b0;
    tick(HALF);
    shift_in(q, 8'h05, q ? 2 : 8);
    for (int k = 0; k < (q ? 2 : 8); k++) begin
      sck = 1'b0;
      tick(HALF);
      st = q ? {st[3:0], io_out} : {st[6:0], io_out[1]};
      oe = io_oe;
      sck = 1'b1;
      tick(HALF);
    end
    end_frame(m3);
  endtask

  task automatic fill_mem();
    for (int a = 0; a < DEPTH; a++) begin
      arr_wr_en = 1'b1; arr_wr_addr = ADDR_W'(a); arr_wr_data = {1'b0, 7'(a)};
      tick(1);
    end
    arr_wr_en = 1'b0;
  endtask

  task automatic read_mem(input int a, output logic [DATA_W-1:0] d);
    arr_rd_addr = ADDR_W'(a);
    tick(2);
    d = arr_rd_data;
  endtask

  function automatic string vtag(input int i);
    case (i)
      0, 11:        return "R1";
      1, 3:         return "R10";
      2:            return "R9";
      4:            return "R2";
      5, 6, 7:      return "R3";
      default:      return "R4";
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    checks++; failures++;
    $display("FAIL R11 watchdog expired actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [7:0] st;
    logic [3:0] oe;
    logic [DATA_W-1:0] d;
    int t0;

    // Reset state
    do_reset();
    check("R11 io_oe after reset", io_oe, 4'h0);
    read_status(1'b0, 1'b0, st, oe);
    check("R11 status after reset", st, 8'h00);

    // Table walk
    for (int i = 0; i < 12; i++) begin
      vec_t v = VEC[i];
      do_reset();
      prot_cfg = v.prot;
      fill_mem();
      if (v.wren) send_frame(v.qpi, v.m3, 8'h06, v.qpi ? 2 : 8);
      send_frame(v.qpi, v.m3, v.op, int'(v.nclk));
      tick(20);
      read_status(v.qpi, v.m3, st, oe);
      check($sformatf("%s R6 vec%0d status after command", vtag(i), i), st, {6'b0, v.wren, v.exp});
      check($sformatf("R9 vec%0d status drive enable", i), oe, v.qpi ? 4'hF : 4'h2);
      tick(600);
      read_status(v.qpi, v.m3, st, oe);
      check($sformatf("R7 vec%0d status after window", i), st, {6'b0, v.wren & ~v.exp, 1'b0});
      for (int a = 0; a < DEPTH; a += DEPTH / 2 - 1) begin
        read_mem(a, d);
        check($sformatf("%s R5 vec%0d array[%0d]", vtag(i), i, a), d, v.exp ? 8'hFF : {1'b0, 7'(a)});
      end
    end

    // Busy window: no restart, write enable and host writes ignored
    do_reset();
    prot_cfg = '0;
    fill_mem();
    send_frame(1'b0, 1'b0, 8'h06, 8);
    oe_seen = 1'b0;
    send_frame(1'b0, 1'b0, 8'hC7, 8);
    t0 = t_cs;
    check("R9 single-line io_oe idle during instruction", oe_seen, 1'b0);
    wait_until(t0 + 20);
    send_frame(1'b0, 1'b0, 8'hC7, 8);
    send_frame(1'b0, 1'b0, 8'h06, 8);
    read_status(1'b0, 1'b0, st, oe);
    check("R6 status polled during erase", st, 8'h03);
    arr_wr_en = 1'b1; arr_wr_addr = ADDR_W'(3); arr_wr_data = 8'h12;
    tick(1);
    arr_wr_en = 1'b0;
    wait_until(t0 + 405);
    read_status(1'b0, 1'b0, st, oe);
    check("R8 no restart and write enable ignored while busy", st, 8'h00);
    read_mem(3, d);
    check("R8 host write during erase dropped", d, 8'hFF);
    read_mem(0, d);
    check("R5 first location blank", d, 8'hFF);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule